// File: doc/BRIEF.md
# Echo-Paced Serial Command Sender

This block drives a battery-powered serial receiver that echoes every character it gets. A command is one letter followed by a carriage return. The block passes each character to a separate UART transmitter. It then waits for the same character to come back on the receive stream. After the echo it holds off for a fixed guard time before presenting the next character. The next character is gated by the echo and the guard, never by the transmitter going idle.

A client requests one of three operations through a valid/ready handshake: query signal quality, request a resync, or request a timestamp. When the carriage return has been echoed, the block forwards receive bytes to a downstream parser until the expected reply length has arrived. The resync command has no reply. The timestamp reply may start late, so the reply window is long. A missing echo, a wrong echo, an unsupported request or a stalled reply ends the command with a one-cycle error pulse. The UART runs at 300 baud with 8 data bits, 2 stop bits and no parity, and lives outside this block.

All waits are clock-cycle counters. Each counter limit is a millisecond parameter scaled by a clock-frequency parameter.

Top module: `cmd_pacer`

## Requirements
- R1: After reset, cmd_ready is 1 and tx_valid, resp_valid, done and err are 0.
- R2: Request code 0 sends 0x67, code 1 sends 0x68 and code 2 sends 0x6F. Each letter is followed by 0x0D, and tx_valid never carries any other byte.
- R3: While tx_valid is high and tx_ready is low, tx_valid stays high and tx_data stays unchanged.
- R4: An echo is compared only on bits 3:0 with the byte last sent. A difference in bits 7:4 is ignored.
- R5: The next character is presented exactly GUARD cycles (clock Hz / 1000 × guard ms) after the cycle in which its predecessor's echo was sampled.
- R6: If no echo arrives within ECHO cycles of the transmit handshake, err pulses exactly ECHO cycles after that handshake. The block then returns to ready without sending more.
- R7: An echo whose bits 3:0 differ from the byte sent aborts the command, with err in the following cycle.
- R8: Request code 3 is accepted and raises err in the next cycle. Nothing is transmitted.
- R9: For codes 0 and 2, receive bytes after the echoed CR appear on resp_valid/resp_data in the same cycle. The reply is 2 bytes for code 0 and 15 bytes for code 2. resp_last marks the final byte, and done pulses in the next cycle.
- R10: A reply byte is accepted up to RESP-1 cycles after the previous reply event (the CR echo or the prior byte). If RESP cycles pass with no byte, err pulses and the command ends.
- R11: For code 1, done pulses GUARD cycles after the CR echo, and no reply byte is forwarded.
- R12: Receive bytes outside the reply phase never reach resp_valid.
- R13: done and err are never high together, and done is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 2 | Command code: 0 quality, 1 resync, 2 timestamp, 3 invalid |
| cmd_ready | output | 1 | Block idle and accepting a command |
| tx_valid | output | 1 | Byte offered to the UART transmitter |
| tx_data | output | 8 | Byte to transmit |
| tx_ready | input | 1 | UART transmitter takes the byte |
| rx_valid | input | 1 | Byte received from the UART |
| rx_data | input | 8 | Received byte |
| resp_valid | output | 1 | Reply byte for the parser |
| resp_data | output | 8 | Reply byte value |
| resp_last | output | 1 | Final reply byte of the command |
| done | output | 1 | Command completed pulse |
| err | output | 1 | Command aborted pulse |

## Verification
The assertions check the following on every cycle:
- the transmit byte set and its stability under back-pressure;
- the separation of done and err;
- that reply bytes only flow while a command is active;
- that resp_last is followed by done.

Other behaviour needs timed stimulus from the bench scenarios:
- the exact guard spacing;
- the echo and reply timeout instants;
- low-nibble echo matching;
- the per-command reply lengths.

// File: rtl/cmd_pacer.sv
module cmd_pacer #(
  parameter int CLK_HZ   = 50_000_000,
  parameter int GUARD_MS = 10,
  parameter int ECHO_MS  = 100,
  parameter int RESP_MS  = 1200
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [1:0] cmd_op,
  output logic       cmd_ready,
  output logic       tx_valid,
  output logic [7:0] tx_data,
  input  logic       tx_ready,
  input  logic       rx_valid,
  input  logic [7:0] rx_data,
  output logic       resp_valid,
  output logic [7:0] resp_data,
  output logic       resp_last,
  output logic       done,
  output logic       err
);
  localparam int PER_MS    = CLK_HZ / 1000;
  localparam int GUARD_CYC = PER_MS * GUARD_MS;
  localparam int ECHO_CYC  = PER_MS * ECHO_MS;
  localparam int RESP_CYC  = PER_MS * RESP_MS;
  localparam int MAX_A     = (GUARD_CYC > ECHO_CYC) ? GUARD_CYC : ECHO_CYC;
  localparam int MAX_CYC   = (MAX_A > RESP_CYC) ? MAX_A : RESP_CYC;
  localparam int TW        = $clog2(MAX_CYC + 1);
  localparam logic [TW-1:0] GUARD_END = TW'(GUARD_CYC - 1);
  localparam logic [TW-1:0] ECHO_END  = TW'(ECHO_CYC - 1);
  localparam logic [TW-1:0] RESP_END  = TW'(RESP_CYC - 1);
  localparam logic [7:0] CR = 8'h0D;

  typedef enum logic [2:0] {S_IDLE, S_SEND, S_ECHO, S_GUARD, S_RESP} st_t;

  st_t           st;
  logic [1:0]    op;
  logic          second;
  logic [TW-1:0] tmr;
  logic [3:0]    rcnt;
  logic          done_q, err_q;
  logic [7:0]    letter, tx_byte;
  logic [3:0]    need;

  assign letter  = (op == 2'd0) ? 8'h67 : (op == 2'd1) ? 8'h68 : 8'h6F;
  assign tx_byte = second ? CR : letter;
  assign need    = (op == 2'd2) ? 4'd15 : 4'd2;

  assign cmd_ready  = (st == S_IDLE);
  assign tx_valid   = (st == S_SEND);
  assign tx_data    = tx_byte;
  assign resp_valid = (st == S_RESP) && rx_valid;
  assign resp_data  = rx_data;
  assign resp_last  = resp_valid && (rcnt == need - 4'd1);
  assign done       = done_q;
  assign err        = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      op     <= 2'd0;
      second <= 1'b0;
      tmr    <= '0;
      rcnt   <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      tmr    <= tmr + 1'b1;
      case (st)
        S_IDLE:
          if (cmd_valid) begin
            if (cmd_op == 2'd3) err_q <= 1'b1;
            else begin
              op     <= cmd_op;
              second <= 1'b0;
              st     <= S_SEND;
            end
          end
        S_SEND:
          if (tx_ready) begin
            st  <= S_ECHO;
            tmr <= '0;
          end
        S_ECHO:
          if (rx_valid) begin
            tmr <= '0;
            if (rx_data[3:0] != tx_byte[3:0]) begin
              err_q <= 1'b1;
              st    <= S_IDLE;
            end else if (!second || op == 2'd1) begin
              st <= S_GUARD;
            end else begin
              rcnt <= '0;
              st   <= S_RESP;
            end
          end else if (tmr == ECHO_END) begin
            err_q <= 1'b1;
            st    <= S_IDLE;
          end
        S_GUARD:
          if (tmr == GUARD_END) begin
            if (!second) begin
              second <= 1'b1;
              st     <= S_SEND;
            end else begin
              done_q <= 1'b1;
              st     <= S_IDLE;
            end
          end
        S_RESP:
          if (rx_valid) begin
            tmr  <= '0;
            rcnt <= rcnt + 4'd1;
            if (rcnt == need - 4'd1) begin
              done_q <= 1'b1;
              st     <= S_IDLE;
            end
          end else if (tmr == RESP_END) begin
            err_q <= 1'b1;
            st    <= S_IDLE;
          end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cmd_pacer_chk.sv
module cmd_pacer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_ready,
  input logic       tx_valid,
  input logic [7:0] tx_data,
  input logic       tx_ready,
  input logic       resp_valid,
  input logic       resp_last,
  input logic       done,
  input logic       err
);
  // R2
  tx_byte_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (tx_data == 8'h67 || tx_data == 8'h68 || tx_data == 8'h6F || tx_data == 8'h0D));
  // R3
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
  // R9
  last_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_last |=> done);
  // R9
  last_in_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_last |-> resp_valid);
  // R12
  resp_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> (!cmd_ready && !tx_valid));
  // R13
  done_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));
  // R13
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind cmd_pacer cmd_pacer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready), .tx_valid(tx_valid),
  .tx_data(tx_data), .tx_ready(tx_ready), .resp_valid(resp_valid),
  .resp_last(resp_last), .done(done), .err(err)
);

// File: tb/cmd_pacer_bench.sv
`timescale 1ns/1ps
module cmd_pacer_bench;
  localparam int HZ = 2000;
  localparam int G  = HZ / 1000 * 10;
  localparam int E  = HZ / 1000 * 100;
  localparam int RW = HZ / 1000 * 1200;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, tx_ready = 1, rx_valid = 0;
  logic [1:0] cmd_op = 0;
  logic [7:0] rx_data = 0;
  logic cmd_ready, tx_valid, resp_valid, resp_last, done, err;
  logic [7:0] tx_data, resp_data;
  int checks = 0, fails = 0;
  logic s_rv, s_rl; logic [7:0] s_rd;

  always #2 clk = ~clk;

  cmd_pacer #(.CLK_HZ(HZ), .GUARD_MS(10), .ECHO_MS(100), .RESP_MS(1200)) u_cmd_pacer (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_ready(cmd_ready),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready), .rx_valid(rx_valid),
    .rx_data(rx_data), .resp_valid(resp_valid), .resp_data(resp_data), .resp_last(resp_last),
    .done(done), .err(err));

  function automatic logic [7:0] exp_letter(input logic [1:0] o);
    return (o == 0) ? 8'h67 : (o == 1) ? 8'h68 : 8'h6F;
  endfunction
  function automatic int exp_len(input logic [1:0] o);
    return (o == 2) ? 15 : (o == 0) ? 2 : 0;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] o);
    @(negedge clk); cmd_valid = 1; cmd_op = o;
    @(negedge clk); cmd_valid = 0;
  endtask
  task automatic get_tx(output logic [7:0] b);
    while (!tx_valid) @(negedge clk);
    b = tx_data;
  endtask
  task automatic rx_pulse(input logic [7:0] b);
    @(negedge clk); rx_valid = 1; rx_data = b;
    #1; s_rv = resp_valid; s_rd = resp_data; s_rl = resp_last;
    @(negedge clk); rx_valid = 0;
  endtask
  task automatic until_tx(output int n);
    n = 1;
    while (!tx_valid) begin @(negedge clk); n++; end
  endtask
  task automatic until_done(output int n, output bit saw_resp);
    n = 1; saw_resp = 0;
    while (!done && !err) begin
      @(negedge clk); n++;
      if (resp_valid) saw_resp = 1;
    end
  endtask
  task automatic until_err(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!err && n < 5000);
  endtask

  task automatic run_cmd(input logic [1:0] o, input int d1, input int d2, input bit hi_noise);
    logic [7:0] b; int n; bit sr; int len;
    issue(o);
    get_tx(b);
    chk(b == exp_letter(o), "R2 letter", b, exp_letter(o));
    repeat (d1) @(negedge clk);
    rx_pulse(hi_noise ? ((8'($urandom) & 8'hF0) | (b & 8'h0F)) : b);
    until_tx(n);
    chk(n == G + 1, "R5 guard", n, G + 1);
    if (hi_noise) chk(1'b1 && n == G + 1, "R4 upper bits ignored", n, G + 1);
    get_tx(b);
    chk(b == 8'h0D, "R2 CR", b, 13);
    repeat (d2) @(negedge clk);
    rx_pulse(8'h0D);
    len = exp_len(o);
    if (len == 0) begin
      until_done(n, sr);
      chk(n == G + 1 && done, "R11 resync done", n, G + 1);
      chk(!sr, "R11 no reply", sr, 0);
    end else begin
      for (int i = 0; i < len; i++) begin
        logic [7:0] v;
        v = 8'($urandom);
        repeat ($urandom % 8) @(negedge clk);
        rx_pulse(v);
        chk(s_rv && s_rd == v, "R9 reply byte", s_rd, v);
        chk(s_rl == (i == len - 1), "R9 last flag", s_rl, i == len - 1);
      end
      chk(done && !err, "R9 done", done, 1);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] b; int n; bit sr;
    process::self().srandom(32'd1234);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(cmd_ready && !tx_valid && !resp_valid && !done && !err, "R1 reset", {cmd_ready, tx_valid, resp_valid, done, err}, 5'b10000);

    // R12 idle rx ignored
    rx_pulse(8'h55);
    chk(!s_rv, "R12 idle rx", s_rv, 0);

    // directed commands, including longest accepted echo delay (R4 noise)
    run_cmd(2'd0, 0, 0, 1'b0);
    run_cmd(2'd1, E - 2, 3, 1'b1);
    run_cmd(2'd2, 5, E - 2, 1'b1);

    for (int k = 0; k < 12; k++)
      run_cmd(2'($urandom % 3), $urandom % 30, $urandom % 30, 1'($urandom));

    // R3 back-pressure
    tx_ready = 0;
    issue(2'd1);
    get_tx(b);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk(tx_valid && tx_data == b, "R3 hold", tx_data, b);
    end
    tx_ready = 1;
    rx_pulse(b);
    until_tx(n);
    get_tx(b);
    rx_pulse(8'h0D);
    until_done(n, sr);

    // R6 echo timeout
    issue(2'd2);
    get_tx(b);
    until_err(n);
    chk(n == E + 1, "R6 echo timeout", n, E + 1);
    chk(cmd_ready && !tx_valid && !done, "R6 back to ready", cmd_ready, 1);
    repeat (G) @(negedge clk);
    chk(!tx_valid, "R6 no further tx", tx_valid, 0);

    // R7 mismatch
    issue(2'd0);
    get_tx(b);
    rx_pulse(8'h68);
    chk(err && cmd_ready, "R7 mismatch", err, 1);

    // R8 invalid op
    issue(2'd3);
    chk(err && !tx_valid && cmd_ready, "R8 invalid op", err, 1);

    // R10 late first byte accepted, then stall -> err
    issue(2'd2);
    get_tx(b); rx_pulse(b); until_tx(n);
    get_tx(b); rx_pulse(8'h0D);
    repeat (RW - 3) @(negedge clk);
    rx_pulse(8'hA5);
    chk(s_rv && s_rd == 8'hA5, "R10 late byte", s_rd, 8'hA5);
    until_err(n);
    chk(n == RW, "R10 reply timeout", n, RW);
    chk(!done && cmd_ready, "R10 aborted", done, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule